// File: doc/BRIEF.md
# Three-Axis Sample Register Bank

This block stores the most recent X, Y and Z samples from a sensing path and presents them to a host as bytes in a small register file. The sensing path offers a full set of three 16-bit two's-complement values with a one-cycle strobe. The host reads one byte at a time through an address, a read strobe and a registered read-data bus. The read data appears on the cycle after the strobe.

Next to the data bytes, a status byte reports which axes hold unread data and which axes lost a sample to a newer one. A data-ready pin, with selectable polarity, flags a set that has not yet been read. Two options change how the host sees the bytes. The coherent-pair option freezes an axis while its two bytes are being read, so both bytes always come from the same sample. The byte-swap option exchanges the high and low byte addresses.

Top module: `sens_regbank`

## Requirements
- R1: Axis bytes sit at 28h..2Dh as X low, X high, Y low, Y high, Z low, Z high when `swap_en`=0. `rd_data` shows the addressed byte on the cycle after `rd_en`.
- R2: A sample for an axis whose bit in `axis_en` (bit0 X, bit1 Y, bit2 Z) is clear is stored as 0000h.
- R3: The status byte at 27h has these bits. Bit 3 is the OR of the new-data flags of the enabled axes. Bits 2, 1 and 0 are the new-data flags of Z, Y and X. Every sample strobe sets all three flags. An axis flag clears when that axis's odd address (29h, 2Bh, 2Dh) is read.
- R4: In the status byte, bit 7 is the OR of the enabled axes' overrun flags, and bits 6, 5 and 4 are the overrun flags of Z, Y and X. An axis's overrun flag sets when a sample arrives while its new-data flag is still set and its odd address is not read in that cycle. A read of that odd address clears the overrun flag.
- R5: When `drdy_high`=1, `drdy` equals status bit 3. It rises after a sample strobe and falls once the odd addresses of all enabled axes have been read.
- R6: When `drdy_high`=0, `drdy` is the inverse of status bit 3.
- R7: With `bdu_en`=1, reading either byte of an axis freezes that axis's value until its other byte has been read. Other axes keep updating.
- R8: A sample that arrives while an axis is frozen is held, and only the newest one is kept. It becomes visible as soon as the freeze ends.
- R9: With `swap_en`=1, the high byte of each axis reads at the even address and the low byte at the odd address.
- R10: A read of any address other than 27h..2Dh returns 00h. Reads of 27h or of unmapped addresses change no state.
- R11: After reset, all stored values and flags are zero, `rd_data` is 00h and `drdy` is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| axis_en | input | 3 | Axis enables: bit0 X, bit1 Y, bit2 Z |
| bdu_en | input | 1 | Coherent-pair (freeze) option |
| swap_en | input | 1 | Byte-order swap option |
| drdy_high | input | 1 | 1: drdy active high, 0: active low |
| smp_valid | input | 1 | One-cycle strobe of a new sample set |
| smp_x | input | 16 | X sample, two's complement, left-justified |
| smp_y | input | 16 | Y sample |
| smp_z | input | 16 | Z sample |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host byte address |
| rd_data | output | 8 | Registered read data |
| drdy | output | 1 | Data-ready indication |

## Verification
The bench goes after the cases where a read and a sample strobe land in the same cycle as the start or the end of a freeze. Getting the start wrong returns a high and low byte from different samples. Getting the end wrong loses or misorders the pending sample. It also checks that overrun clears only through a read of the odd address: a design that cleared it on a status read, or on a read of the low byte, would hide lost samples. It checks that data-ready waits for every enabled axis and ignores disabled ones, since an AND-based or all-axis combination would drop early or never drop at all. Byte swap is checked together with the freeze, because a design keyed to logical bytes instead of addresses would leave the lock unreleased.

// File: rtl/sens_pkg.sv
// Shared constants for the sample register bank.
// Assumes three axes and 16-bit samples split into two bytes.
package sens_pkg;
    localparam int NAXES  = 3;
    localparam int BYTE_W = 8;
    typedef logic [2*BYTE_W-1:0] sample_t;
endpackage

// File: rtl/sens_axis_slot.sv
// One axis: held value, pending value, freeze tracking and data/overrun flags.
// Assumes rd_lo/rd_hi are one-cycle strobes for this axis's even/odd address.
module sens_axis_slot
    import sens_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bdu_en,
    input  logic    ax_en,
    input  logic    smp_valid,
    input  sample_t smp_val,
    input  logic    rd_lo,
    input  logic    rd_hi,
    output sample_t held,
    output logic    da,
    output logic    ovr
);
    sample_t pend_q, val;
    logic    pend_v, lock_q, lo_q, hi_q;
    logic    seen_lo, seen_hi, claim, done, lock_d;

    // Work out whether this axis is frozen after the current edge.
    always_comb begin
        seen_lo = lo_q | rd_lo;
        seen_hi = hi_q | rd_hi;
        claim   = bdu_en && (lock_q || rd_lo || rd_hi);
        done    = claim && seen_lo && seen_hi;
        lock_d  = claim && !done;
        val     = ax_en ? smp_val : '0;
    end

    // Store samples either in the held register or, while frozen, in the pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held   <= '0;
            pend_q <= '0;
            pend_v <= 1'b0;
            lock_q <= 1'b0;
            lo_q   <= 1'b0;
            hi_q   <= 1'b0;
        end else begin
            lock_q <= lock_d;
            lo_q   <= lock_d & seen_lo;
            hi_q   <= lock_d & seen_hi;
            if (smp_valid) begin
                if (lock_d) begin
                    pend_q <= val;
                    pend_v <= 1'b1;
                end else begin
                    held   <= val;
                    pend_v <= 1'b0;
                end
            end else if (pend_v && !lock_d) begin
                held   <= pend_q;
                pend_v <= 1'b0;
            end
        end
    end

    // Track unread data and lost samples; an odd-address read drains both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            da  <= 1'b0;
            ovr <= 1'b0;
        end else begin
            if (smp_valid) da <= 1'b1;
            else if (rd_hi) da <= 1'b0;
            if (smp_valid && da && !rd_hi) ovr <= 1'b1;
            else if (rd_hi) ovr <= 1'b0;
        end
    end

    AST_DA_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> da); // R3
    AST_OVR_NEEDS_DA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(da)); // R4
    AST_LOCK_NEEDS_BDU: assert property (@(posedge clk) disable iff (!rst_n)
        !bdu_en |=> !lock_q); // R7
    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q ##1 lock_q |-> $stable(held)); // R7
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !ax_en && !lock_d) |=> (held == '0)); // R2
endmodule

// File: rtl/sens_status_comb.sv
// Builds the status byte and the data-ready pin from the per-axis flags.
// Assumes three axes in X, Y, Z order on bit positions 0, 1, 2.
module sens_status_comb
    import sens_pkg::*;
(
    input  logic [NAXES-1:0] axis_en,
    input  logic [NAXES-1:0] da,
    input  logic [NAXES-1:0] ovr,
    input  logic             drdy_high,
    output logic [7:0]       status,
    output logic             drdy
);
    logic any_da, any_ovr;

    // Combine the enabled axes and lay out the status byte.
    always_comb begin
        any_da  = |(da & axis_en);
        any_ovr = |(ovr & axis_en);
        status  = {any_ovr, ovr[2], ovr[1], ovr[0], any_da, da[2], da[1], da[0]};
        drdy    = drdy_high ? any_da : !any_da;
    end
endmodule

// File: rtl/sens_regbank.sv
// Top: three axis slots, status combiner and the registered host read port.
// Assumes single-byte host reads; read data is valid the cycle after rd_en.
module sens_regbank
    import sens_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h27,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        axis_en,
    input  logic              bdu_en,
    input  logic              swap_en,
    input  logic              drdy_high,
    input  logic              smp_valid,
    input  logic [15:0]       smp_x,
    input  logic [15:0]       smp_y,
    input  logic [15:0]       smp_z,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              drdy
);
    sample_t          smp_arr [NAXES];
    sample_t          held    [NAXES];
    logic [NAXES-1:0] da, ovr, hit_lo, hit_hi;
    logic [7:0]       status, sel;
    logic             mapped;

    assign smp_arr[0] = smp_x;
    assign smp_arr[1] = smp_y;
    assign smp_arr[2] = smp_z;

    for (genvar g = 0; g < NAXES; g++) begin : g_axis
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(DATA_ADDR + ADDR_W'(2*g));
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(DATA_ADDR + ADDR_W'(2*g + 1));
        assign hit_lo[g] = rd_en && (rd_addr == LO_A);
        assign hit_hi[g] = rd_en && (rd_addr == HI_A);
        sens_axis_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .bdu_en    (bdu_en),
            .ax_en     (axis_en[g]),
            .smp_valid (smp_valid),
            .smp_val   (smp_arr[g]),
            .rd_lo     (hit_lo[g]),
            .rd_hi     (hit_hi[g]),
            .held      (held[g]),
            .da        (da[g]),
            .ovr       (ovr[g])
        );
    end

    sens_status_comb u_stat (
        .axis_en   (axis_en),
        .da        (da),
        .ovr       (ovr),
        .drdy_high (drdy_high),
        .status    (status),
        .drdy      (drdy)
    );

    // Select the addressed byte, applying the optional byte swap.
    always_comb begin
        sel    = '0;
        mapped = (rd_addr == STAT_ADDR);
        if (rd_addr == STAT_ADDR) sel = status;
        for (int a = 0; a < NAXES; a++) begin
            if (rd_addr == ADDR_W'(DATA_ADDR + ADDR_W'(2*a))) begin
                sel    = swap_en ? held[a][15:8] : held[a][7:0];
                mapped = 1'b1;
            end
            if (rd_addr == ADDR_W'(DATA_ADDR + ADDR_W'(2*a + 1))) begin
                sel    = swap_en ? held[a][7:0] : held[a][15:8];
                mapped = 1'b1;
            end
        end
    end

    // Register the read data on each host strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rd_data == 8'h00)); // R10
    AST_NO_STRAY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !(|hit_hi)) |=> (da == $past(da))); // R10
    AST_DRDY_FALLS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_high && $fell(drdy) && $stable(drdy_high) && $stable(axis_en)) |-> $past(|hit_hi)); // R5
endmodule

// File: tb/sens_regbank_test.sv
module sens_regbank_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic [2:0]  axis_en = 3'b111;
    logic        bdu_en = 1'b0, swap_en = 1'b0, drdy_high = 1'b1;
    logic        smp_valid = 1'b0, rd_en = 1'b0;
    logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        drdy;

    int errors = 0, checks = 0;
    logic [15:0] m_x [3], m_pend [3];
    bit m_pv [3], m_lock [3], m_lo [3], m_hi [3], m_da [3], m_or [3];
    logic [7:0] last_rd;

    always #2 clk = ~clk;

    sens_regbank uut (
        .clk(clk), .rst_n(rst_n), .axis_en(axis_en), .bdu_en(bdu_en),
        .swap_en(swap_en), .drdy_high(drdy_high), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .drdy(drdy)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_status();
        bit anyd = 0, anyo = 0;
        for (int a = 0; a < 3; a++) begin
            anyd |= m_da[a] & axis_en[a];
            anyo |= m_or[a] & axis_en[a];
        end
        return {anyo, m_or[2], m_or[1], m_or[0], anyd, m_da[2], m_da[1], m_da[0]};
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'h27) return exp_status();
        for (int k = 0; k < 3; k++) begin
            if (a == 8'h28 + 8'(2*k))     return swap_en ? m_x[k][15:8] : m_x[k][7:0];
            if (a == 8'h28 + 8'(2*k + 1)) return swap_en ? m_x[k][7:0]  : m_x[k][15:8];
        end
        return 8'h00;
    endfunction

    // Reference model of one clock edge, written from the requirements.
    task automatic model_edge(input bit s, input logic [15:0] sv [3], input bit r, input logic [7:0] a);
        for (int k = 0; k < 3; k++) begin
            bit lo_h = r && (a == 8'h28 + 8'(2*k));
            bit hi_h = r && (a == 8'h28 + 8'(2*k + 1));
            bit slo = m_lo[k] | lo_h, shi = m_hi[k] | hi_h;
            bit claim = bdu_en && (m_lock[k] || lo_h || hi_h);
            bit nlock = claim && !(slo && shi);
            logic [15:0] v = axis_en[k] ? sv[k] : 16'h0000;
            if (s) begin
                if (nlock) begin m_pend[k] = v; m_pv[k] = 1; end
                else begin m_x[k] = v; m_pv[k] = 0; end
            end else if (m_pv[k] && !nlock) begin
                m_x[k] = m_pend[k]; m_pv[k] = 0;
            end
            m_lock[k] = nlock;
            m_lo[k] = nlock & slo;
            m_hi[k] = nlock & shi;
            if (s && m_da[k] && !hi_h) m_or[k] = 1;
            else if (hi_h) m_or[k] = 0;
            if (s) m_da[k] = 1;
            else if (hi_h) m_da[k] = 0;
        end
    endtask

    task automatic step(input bit s, input logic [15:0] x, y, z, input bit r,
                        input logic [7:0] a, input string tag);
        logic [7:0] exp;
        logic [15:0] sv [3];
        bit anyd;
        @(negedge clk);
        smp_valid = s; smp_x = x; smp_y = y; smp_z = z;
        rd_en = r; rd_addr = a;
        sv[0] = x; sv[1] = y; sv[2] = z;
        exp = exp_read(a);
        model_edge(s, sv, r, a);
        @(posedge clk);
        #1;
        smp_valid = 0; rd_en = 0;
        last_rd = rd_data;
        if (r) chk(rd_data, exp, tag);
        anyd = 0;
        for (int k = 0; k < 3; k++) anyd |= m_da[k] & axis_en[k];
        chk({7'd0, drdy}, {7'd0, drdy_high ? anyd : !anyd}, "R5 drdy");
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(0, 0, 0, 0, 1, a, tag);
    endtask

    task automatic smp(input logic [15:0] x, y, z);
        step(1, x, y, z, 0, 8'h00, "R3");
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] st0;
        void'($urandom(32'd4242));
        for (int k = 0; k < 3; k++) begin
            m_x[k] = 0; m_pend[k] = 0; m_pv[k] = 0; m_lock[k] = 0;
            m_lo[k] = 0; m_hi[k] = 0; m_da[k] = 0; m_or[k] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        chk(rd_data, 8'h00, "R11 rd_data");
        chk({7'd0, drdy}, 8'h00, "R11 drdy");
        rst_n = 1'b1;

        smp(16'h0400, 16'hC000, 16'h1234);
        chk({7'd0, drdy}, 8'h01, "R5 rise");
        rd(8'h28, "R1"); chk(last_rd, 8'h00, "R1 x low");
        rd(8'h29, "R1"); chk(last_rd, 8'h04, "R1 x high");
        rd(8'h27, "R3"); chk(last_rd, 8'h0E, "R3 status");
        rd(8'h2B, "R1"); chk(last_rd, 8'hC0, "R1 y high");
        rd(8'h2D, "R1"); chk({7'd0, drdy}, 8'h00, "R5 fall");
        drdy_high = 1'b0;
        #1 chk({7'd0, drdy}, 8'h01, "R6 inverted");
        drdy_high = 1'b1;

        smp(16'h1111, 16'h2222, 16'h3333);
        smp(16'h4444, 16'h5555, 16'h6666);
        rd(8'h27, "R4"); chk(last_rd, 8'hFF, "R4 overrun set");
        rd(8'h28, "R4"); rd(8'h27, "R4"); chk(last_rd, 8'hFF, "R4 low read keeps");
        rd(8'h29, "R4"); rd(8'h2B, "R4"); rd(8'h2D, "R4");
        rd(8'h27, "R4"); chk(last_rd, 8'h00, "R4 drained");

        axis_en = 3'b101;
        smp(16'h1010, 16'h7777, 16'h2020);
        rd(8'h2A, "R2"); chk(last_rd, 8'h00, "R2 y low");
        rd(8'h2B, "R2"); chk(last_rd, 8'h00, "R2 y high");
        smp(16'h1010, 16'h7777, 16'h2020);
        rd(8'h29, "R3"); rd(8'h2D, "R3");
        rd(8'h27, "R3"); chk(last_rd, 8'h02, "R3 disabled axis excluded");
        axis_en = 3'b111;

        swap_en = 1'b1;
        smp(16'h0400, 16'h0000, 16'h0000);
        rd(8'h28, "R9"); chk(last_rd, 8'h04, "R9 swap even");
        rd(8'h29, "R9"); chk(last_rd, 8'h00, "R9 swap odd");
        swap_en = 1'b0;

        bdu_en = 1'b1;
        smp(16'h1122, 16'h0000, 16'h0000);
        rd(8'h28, "R7"); chk(last_rd, 8'h22, "R7 low");
        smp(16'h3344, 16'h5566, 16'h0000);
        smp(16'h7788, 16'h99AA, 16'h0000);
        rd(8'h2A, "R7"); chk(last_rd, 8'hAA, "R7 other axis updates");
        rd(8'h2B, "R7");
        rd(8'h29, "R7"); chk(last_rd, 8'h11, "R7 frozen high");
        rd(8'h28, "R8"); chk(last_rd, 8'h88, "R8 newest pending low");
        rd(8'h29, "R8"); chk(last_rd, 8'h77, "R8 newest pending high");
        bdu_en = 1'b0;

        rd(8'h27, "R10"); st0 = last_rd;
        rd(8'h40, "R10"); chk(last_rd, 8'h00, "R10 unmapped");
        rd(8'h26, "R10"); chk(last_rd, 8'h00, "R10 below range");
        rd(8'h27, "R10"); chk(last_rd, st0, "R10 no side effect");

        for (int i = 0; i < 4000; i++) begin
            bit s, r;
            logic [7:0] a;
            string tag;
            if ($urandom % 60 == 0) begin
                axis_en = 3'($urandom); bdu_en = 1'($urandom);
                swap_en = 1'($urandom); drdy_high = 1'($urandom);
            end
            s = ($urandom % 3 == 0);
            r = ($urandom % 5 < 3);
            a = ($urandom % 10 == 0) ? 8'($urandom) : 8'h27 + 8'($urandom % 7);
            if (a == 8'h27) tag = "R4 status";
            else if (a < 8'h27 || a > 8'h2D) tag = "R10 random";
            else if (bdu_en) tag = "R7 random";
            else if (swap_en) tag = "R9 random";
            else tag = "R1 random";
            step(s, 16'($urandom), 16'($urandom), 16'($urandom), r, a, tag);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule